// File: doc/BRIEF.md
# Round-Robin Transmit Descriptor Engine

This block is the device-side engine behind four transmit descriptor slots. Each slot has a status/size register and a start-address register on a simple register bus. Host software loads a slot's address, then writes its status register with a byte count and an early-start threshold. That write queues the frame. The engine services the slots in a fixed rotation. For each frame it fetches the bytes from memory through a one-byte read port into a local frame buffer. It streams them out on a byte port with a valid/ready handshake and pads short frames with zero bytes. It reports the outcome in two completion bits of the slot's status word.

The control is a four-state machine:
- **IDLE** waits for the slot under the rotation pointer to be queued. It takes one of two transitions:
  - *reject*: an oversize frame is retired at once and IDLE is kept.
  - *launch*: the fetch starts and the machine moves to LOAD.
- **LOAD** moves to SEND on *threshold-met*. That happens once the fetched byte count reaches the threshold or covers the whole frame.
- **SEND** streams bytes. It moves to CLOSE on *last-accepted* when the final byte is taken, or on *give-up* when an abort arrives on the last allowed attempt. Any other abort is the *retry* transition, which stays in SEND and restarts from byte 0.
- **CLOSE** waits for the fetch to finish. It then takes *retire*: it writes the result bits, advances the rotation pointer and returns to IDLE.

Top module: `txq_ring_engine`

## Requirements
- R1: Slots are serviced strictly in the order 0,1,2,3,0,… (next = current + 1 modulo 4). The engine waits on the current slot even when a later slot was queued first, so the later slot is sent after it.
- R2: Register map, with byte addresses:
  - The status word of slot n is at 0x10+4n and its start address is at 0x20+4n.
  - The configuration register is at 0x40, with the 4-bit retry selector in bits 7:4.
  - Status layout: size in bits 12:0, OWN in bit 13, TOK in bit 15, threshold in bits 21:16. All other bits read 0.
  - Every register reads 0 after reset.
- R3: Writing a status register stores the size and the threshold and clears OWN and TOK in that slot. A non-zero size queues the frame. A size of 0 leaves the slot free and nothing is sent.
- R4: OWN rises, no earlier than the cycle after the status write, once all size bytes have been fetched. TOK rises when the last byte of the frame is accepted on the transmit port. TOK is never 1 while OWN is 0.
- R5: A frame shorter than 60 bytes goes out as exactly 60 bytes, with zero bytes after the payload. Longer frames go out at their own size. tx_last marks the final byte.
- R6: A size above 1516 is rejected. No byte is sent, the status reads OWN=1 and TOK=0, and the rotation moves on to the next slot.
- R7: Transmission of a frame does not begin until the fetched byte count reaches threshold×32 or the whole frame, whichever is smaller.
- R8: Frame byte i is read from memory address start+i. The read data is valid in the same cycle as mem_rd_en, and each byte is read exactly once per frame.
- R9: An abort pulse during sending restarts the frame from byte 0. The attempt limit is 16+16×selector. An abort on the final allowed attempt ends the frame with OWN=1 and TOK=0.
- R10: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write byte address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read byte address |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_rd_en | output | 1 | Memory byte read request |
| mem_addr | output | 32 | Memory byte address |
| mem_rdata | input | 8 | Memory read data, same cycle |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Transmit port accepts the byte |
| tx_abort | input | 1 | Abort the current attempt (collision) |

## Verification
The embedded properties watch, on every cycle:
- that the rotation pointer only steps by one;
- that a status write always leaves OWN and TOK low in the following cycle;
- that TOK never stands without OWN;
- that SEND is entered only with the threshold or the whole frame fetched;
- that the attempt counter stays within the latched limit;
- that stalled bytes hold steady.

Only the bench scenarios can show the rest:
- that byte contents and padded lengths match the programmed memory and sizes;
- that out-of-order queuing still yields slot order;
- that a zero size sends nothing;
- that an oversize frame is skipped with the right status;
- that the attempt limit gives up after exactly the computed number of aborts.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int NSLOT  = 4;
    localparam int IDX_W  = 2;
    localparam int SIZE_W = 13;
    localparam int THR_W  = 6;
    localparam int RR_W   = 4;
    localparam int ATT_W  = 9;

    localparam logic [3:0] STAT_PAGE = 4'h1;
    localparam logic [3:0] ADDR_PAGE = 4'h2;
    localparam logic [7:0] CFG_ADDR  = 8'h40;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOAD,
        S_SEND,
        S_CLOSE
    } eng_state_e;
endpackage

// File: rtl/txq_slot_regs.sv
module txq_slot_regs
    import txq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        waddr,
    input  logic [31:0]       wdata,
    input  logic [7:0]        raddr,
    output logic [31:0]       rdata,
    input  logic [IDX_W-1:0]  cur,
    input  logic              own_set,
    input  logic              retire,
    input  logic              retire_ok,
    output logic              cur_pend,
    output logic [SIZE_W-1:0] cur_size,
    output logic [THR_W-1:0]  cur_thr,
    output logic [ADDR_W-1:0] cur_base,
    output logic [RR_W-1:0]   txrr,
    output logic [NSLOT-1:0]  own_vec,
    output logic [NSLOT-1:0]  tok_vec
);
    logic [SIZE_W-1:0] size_q [NSLOT];
    logic [THR_W-1:0]  thr_q  [NSLOT];
    logic [ADDR_W-1:0] base_q [NSLOT];
    logic [NSLOT-1:0]  own_q, tok_q, pend_q;
    logic [RR_W-1:0]   rr_q;

    logic             w_stat, w_addr, w_cfg;
    logic [IDX_W-1:0] widx, ridx;

    assign w_stat = wr_en && (waddr[7:4] == STAT_PAGE) && (waddr[1:0] == 2'b00);
    assign w_addr = wr_en && (waddr[7:4] == ADDR_PAGE) && (waddr[1:0] == 2'b00);
    assign w_cfg  = wr_en && (waddr == CFG_ADDR);
    assign widx   = waddr[3:2];
    assign ridx   = raddr[3:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) begin
                size_q[i] <= '0;
                thr_q[i]  <= '0;
                base_q[i] <= '0;
            end
            own_q  <= '0;
            tok_q  <= '0;
            pend_q <= '0;
            rr_q   <= '0;
        end else begin
            if (w_cfg) rr_q <= wdata[7:4];
            for (int i = 0; i < NSLOT; i++) begin
                if (w_addr && widx == IDX_W'(i)) base_q[i] <= wdata[ADDR_W-1:0];
                if (w_stat && widx == IDX_W'(i)) begin
                    size_q[i] <= wdata[SIZE_W-1:0];
                    thr_q[i]  <= wdata[16 +: THR_W];
                    own_q[i]  <= 1'b0;
                    tok_q[i]  <= 1'b0;
                    pend_q[i] <= |wdata[SIZE_W-1:0];
                end else if (cur == IDX_W'(i)) begin
                    if (own_set) own_q[i] <= 1'b1;
                    if (retire) begin
                        own_q[i]  <= 1'b1;
                        tok_q[i]  <= retire_ok;
                        pend_q[i] <= 1'b0;
                    end
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (raddr[7:4] == STAT_PAGE && raddr[1:0] == 2'b00)
            rdata = {10'd0, thr_q[ridx], tok_q[ridx], 1'b0, own_q[ridx], size_q[ridx]};
        else if (raddr[7:4] == ADDR_PAGE && raddr[1:0] == 2'b00)
            rdata = 32'(base_q[ridx]);
        else if (raddr == CFG_ADDR)
            rdata = {24'd0, rr_q, 4'd0};
    end

    assign cur_pend = pend_q[cur];
    assign cur_size = size_q[cur];
    assign cur_thr  = thr_q[cur];
    assign cur_base = base_q[cur];
    assign txrr     = rr_q;
    assign own_vec  = own_q;
    assign tok_vec  = tok_q;
endmodule

// File: rtl/txq_fetch.sv
module txq_fetch
    import txq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUF_DEPTH = 2048
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [ADDR_W-1:0]            base,
    input  logic [SIZE_W-1:0]            size,
    output logic                         mem_rd_en,
    output logic [ADDR_W-1:0]            mem_addr,
    input  logic [7:0]                   mem_rdata,
    output logic [SIZE_W-1:0]            fcnt,
    output logic                         busy,
    output logic                         done_pulse,
    input  logic [$clog2(BUF_DEPTH)-1:0] rd_idx,
    output logic [7:0]                   rd_byte
);
    localparam int BW = $clog2(BUF_DEPTH);

    logic [7:0]        buf_q [BUF_DEPTH];
    logic [SIZE_W-1:0] cnt_q;
    logic              act_q;

    assign mem_rd_en  = act_q && (cnt_q < size);
    assign mem_addr   = base + ADDR_W'(cnt_q);
    assign done_pulse = mem_rd_en && (cnt_q == size - 1'b1);
    assign fcnt       = cnt_q;
    assign busy       = act_q;
    assign rd_byte    = buf_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (start) begin
            cnt_q <= '0;
            act_q <= 1'b1;
        end else if (mem_rd_en) begin
            cnt_q <= cnt_q + 1'b1;
            if (done_pulse) act_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_rd_en) buf_q[cnt_q[BW-1:0]] <= mem_rdata;
    end

    // R8
    fetch_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !mem_rd_en);
endmodule

// File: rtl/txq_ring_engine.sv
module txq_ring_engine
    import txq_pkg::*;
#(
    parameter int MIN_LEN   = 60,
    parameter int MAX_LEN   = 1516,
    parameter int BUF_DEPTH = 2048,
    parameter int ADDR_W    = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [7:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    output logic        mem_rd_en,
    output logic [31:0] mem_addr,
    input  logic [7:0]  mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    input  logic        tx_abort
);
    localparam int BW = $clog2(BUF_DEPTH);

    eng_state_e        state_q, nxt;
    logic [IDX_W-1:0]  cur_q;
    logic              cur_pend;
    logic [SIZE_W-1:0] cur_size;
    logic [THR_W-1:0]  cur_thr;
    logic [ADDR_W-1:0] cur_base;
    logic [RR_W-1:0]   txrr;
    logic [NSLOT-1:0]  own_vec, tok_vec;
    logic              start, retire, retire_ok;
    logic [SIZE_W-1:0] fcnt;
    logic              fbusy, fdone;
    logic [7:0]        rd_byte;
    logic [SIZE_W-1:0] size_q, pad_q, sidx_q, thr_b_q;
    logic [ATT_W-1:0]  att_q, lim_q;
    logic              ok_q, hs;

    txq_slot_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .waddr(reg_waddr), .wdata(reg_wdata),
        .raddr(reg_raddr), .rdata(reg_rdata), .cur(cur_q), .own_set(fdone),
        .retire(retire), .retire_ok(retire_ok), .cur_pend(cur_pend), .cur_size(cur_size),
        .cur_thr(cur_thr), .cur_base(cur_base), .txrr(txrr), .own_vec(own_vec), .tok_vec(tok_vec)
    );

    txq_fetch #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH)) fetch_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base(cur_base), .size(size_q),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .fcnt(fcnt),
        .busy(fbusy), .done_pulse(fdone), .rd_idx(sidx_q[BW-1:0]), .rd_byte(rd_byte)
    );

    // Outputs towards the transmit port
    always_comb begin
        tx_valid = (state_q == S_SEND) && ((sidx_q >= size_q) || (sidx_q < fcnt));
        tx_data  = (sidx_q < size_q) ? rd_byte : 8'h00;
        tx_last  = tx_valid && (sidx_q == pad_q - 1'b1);
        hs       = tx_valid && tx_ready && !tx_abort;
    end

    // Next state and control strobes
    always_comb begin
        nxt       = state_q;
        start     = 1'b0;
        retire    = 1'b0;
        retire_ok = 1'b0;
        unique case (state_q)
            S_IDLE: if (cur_pend) begin
                if (cur_size > SIZE_W'(MAX_LEN)) begin
                    retire = 1'b1;
                end else begin
                    start = 1'b1;
                    nxt   = S_LOAD;
                end
            end
            S_LOAD: if (fcnt >= thr_b_q || fcnt == size_q) nxt = S_SEND;
            S_SEND: begin
                if (tx_abort) begin
                    if (att_q == lim_q) nxt = S_CLOSE;
                end else if (hs && tx_last) begin
                    nxt = S_CLOSE;
                end
            end
            S_CLOSE: if (!fbusy) begin
                retire    = 1'b1;
                retire_ok = ok_q;
                nxt       = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            size_q  <= '0;
            pad_q   <= '0;
            thr_b_q <= '0;
            sidx_q  <= '0;
            att_q   <= '0;
            lim_q   <= '0;
            ok_q    <= 1'b0;
        end else begin
            if (retire) cur_q <= cur_q + 1'b1;
            if (start) begin
                size_q  <= cur_size;
                pad_q   <= (cur_size < SIZE_W'(MIN_LEN)) ? SIZE_W'(MIN_LEN) : cur_size;
                thr_b_q <= SIZE_W'({cur_thr, 5'b00000});
                lim_q   <= {({1'b0, txrr} + 5'd1), 4'b0000};
                ok_q    <= 1'b0;
            end
            if (state_q == S_LOAD && nxt == S_SEND) begin
                sidx_q <= '0;
                att_q  <= ATT_W'(1);
            end else if (state_q == S_SEND) begin
                if (tx_abort) begin
                    sidx_q <= '0;
                    if (att_q != lim_q) att_q <= att_q + 1'b1;
                end else if (hs) begin
                    sidx_q <= sidx_q + 1'b1;
                    if (tx_last) ok_q <= 1'b1;
                end
            end
        end
    end

    // R1
    rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q != $past(cur_q)) |-> (cur_q == $past(cur_q) + 1'b1));
    // R7
    thresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == S_SEND) |-> (fcnt >= thr_b_q || fcnt == size_q));
    // R9
    attempt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEND) |-> (att_q <= lim_q && att_q != '0));
    // R10
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !tx_abort) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
    // R6
    size_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (size_q <= SIZE_W'(MAX_LEN)));

    for (genvar i = 0; i < NSLOT; i++) begin : g_chk
        // R3
        stat_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_waddr == 8'(8'h10 + 4 * i)) |=> (!own_vec[i] && !tok_vec[i]));
        // R4
        tok_needs_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tok_vec[i] |-> own_vec[i]);
    end
endmodule

// File: tb/txq_ring_engine_tb_top.sv
`timescale 1ns/1ps
module txq_ring_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        tx_abort = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign mem_rdata = mbyte(mem_addr);

    txq_ring_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_abort(tx_abort)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // expected frame queue, in service order
    logic [31:0] exp_base [32];
    int          exp_size [32];
    int q_tail = 0, q_head = 0, pos = 0;
    bit ferr = 1'b0, ignore_frames = 1'b0;

    function automatic int padded(input int s);
        return (s < 60) ? 60 : s;
    endfunction

    always @(negedge clk) begin
        if (rst_n && tx_valid && !ignore_frames) begin
            if (tx_abort) begin
                pos = 0;
                ferr = 1'b0;
            end else if (tx_ready) begin
                if (q_head >= q_tail) begin
                    if (pos == 0) check(1'b0, "R1 unexpected frame", tx_data, 0);
                    pos++;
                end else begin
                    automatic logic [7:0] e = (pos < exp_size[q_head]) ?
                        mbyte(exp_base[q_head] + 32'(pos)) : 8'h00;
                    if (tx_data != e) ferr = 1'b1;
                    if (tx_last != (pos == padded(exp_size[q_head]) - 1)) ferr = 1'b1;
                    if (tx_last) begin
                        // R8 data order/content, R1 slot order, R5 padding
                        check(!ferr, "R8/R1 frame bytes", q_head, q_head);
                        check(pos + 1 == padded(exp_size[q_head]), "R5 frame length",
                              pos + 1, padded(exp_size[q_head]));
                        q_head++;
                        pos = 0;
                        ferr = 1'b0;
                    end else begin
                        pos++;
                    end
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_raddr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic push(input logic [31:0] b, input int s);
        exp_base[q_tail] = b;
        exp_size[q_tail] = s;
        q_tail++;
    endtask

    task automatic launch(input int slot, input logic [31:0] b, input int s, input int thr);
        wr(8'(8'h20 + 4 * slot), b);
        wr(8'(8'h10 + 4 * slot), (32'(thr) << 16) | 32'(s));
    endtask

    task automatic wait_frames(input int n);
        while (q_head < n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] ok_word(input int s, input int thr);
        return (32'(thr) << 16) | 32'h0000_A000 | 32'(s);
    endfunction

    task automatic abort_pulse();
        @(negedge clk);
        while (!tx_valid) @(negedge clk);
        @(posedge clk); #1 tx_abort = 1'b1;
        @(posedge clk); #1 tx_abort = 1'b0;
    endtask

    task automatic count_valid(input int cycles, output int n);
        n = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (tx_valid) n++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            rd(8'(8'h10 + 4 * i), d); check(d == 0, "R2 status reset", d, 0);
            rd(8'(8'h20 + 4 * i), d); check(d == 0, "R2 address reset", d, 0);
        end
        check(!tx_valid && !mem_rd_en, "R2 outputs idle after reset", {tx_valid, mem_rd_en}, 0);
    endtask

    task automatic t_rotation();
        logic [31:0] d;
        int sz[4] = '{70, 20, 60, 100};
        for (int i = 0; i < 4; i++) begin
            push(32'h1000 * (i + 1), sz[i]);
            launch(i, 32'h1000 * (i + 1), sz[i], 0);
        end
        wait_frames(4);
        for (int i = 0; i < 4; i++) begin
            rd(8'(8'h10 + 4 * i), d);
            check(d == ok_word(sz[i], 0), "R4 status after send", d, ok_word(sz[i], 0));
        end
        push(32'h5000, 59);
        launch(0, 32'h5000, 59, 0);
        rd(8'h10, d);
        check(d == 32'd59, "R3 rewrite clears OWN/TOK", d, 59);
        wait_frames(5);
        rd(8'h10, d);
        check(d == ok_word(59, 0), "R4 reused slot status", d, ok_word(59, 0));
    endtask

    task automatic t_order();
        int n;
        push(32'h7000, 90);
        push(32'h6000, 64);
        launch(2, 32'h6000, 64, 0);
        count_valid(20, n);
        check(n == 0, "R1 waits on current slot", n, 0);
        launch(1, 32'h7000, 90, 0);
        wait_frames(7);
    endtask

    task automatic t_zero();
        logic [31:0] d;
        int n;
        launch(3, 32'h8000, 0, 0);
        count_valid(20, n);
        check(n == 0, "R3 zero size sends nothing", n, 0);
        rd(8'h1C, d);
        check(d == 0, "R3 zero size status", d, 0);
        push(32'h8000, 80);
        wr(8'h1C, 32'd80);
        wait_frames(8);
    endtask

    task automatic t_reject();
        logic [31:0] d;
        int n;
        launch(0, 32'h9000, 1517, 0);
        count_valid(5, n);
        check(n == 0, "R6 oversize not sent", n, 0);
        rd(8'h10, d);
        check(d == 32'h2000 + 1517, "R6 oversize status", d, 32'h2000 + 1517);
        push(32'hA000, 61);
        launch(1, 32'hA000, 61, 0);
        wait_frames(9);
    endtask

    task automatic t_thresh();
        int cnt;
        push(32'hB000, 200);
        wr(8'h28, 32'hB000);
        wr(8'h18, (32'd2 << 16) | 32'd200);
        cnt = 0;
        do begin
            @(negedge clk);
            if (mem_rd_en) cnt++;
        end while (!tx_valid);
        check(cnt >= 64 && cnt <= 66, "R7 threshold 64 bytes", cnt, 64);
        wait_frames(10);
        push(32'hC000, 150);
        wr(8'h2C, 32'hC000);
        wr(8'h1C, (32'd20 << 16) | 32'd150);
        cnt = 0;
        do begin
            @(negedge clk);
            if (mem_rd_en) cnt++;
        end while (!tx_valid);
        check(cnt == 150, "R7 whole frame before threshold", cnt, 150);
        wait_frames(11);
    endtask

    task automatic t_stall();
        logic [7:0] d0;
        logic       l0;
        push(32'hD000, 70);
        launch(0, 32'hD000, 70, 0);
        @(negedge clk);
        while (!tx_valid) @(negedge clk);
        @(posedge clk); #1 tx_ready = 1'b0;
        @(negedge clk);
        d0 = tx_data;
        l0 = tx_last;
        repeat (4) begin
            @(negedge clk);
            check(tx_valid && tx_data == d0 && tx_last == l0, "R10 hold under stall", tx_data, d0);
        end
        @(posedge clk); #1 tx_ready = 1'b1;
        wait_frames(12);
    endtask

    task automatic t_retry_once();
        logic [31:0] d;
        wr(8'h40, 32'h10);
        rd(8'h40, d);
        check(d == 32'h10, "R2 retry selector readback", d, 32'h10);
        push(32'hE000, 120);
        launch(1, 32'hE000, 120, 0);
        abort_pulse();
        wait_frames(13);
        rd(8'h14, d);
        check(d == ok_word(120, 0), "R9 retried frame succeeds", d, ok_word(120, 0));
    endtask

    task automatic t_giveup();
        logic [31:0] d;
        int n;
        wr(8'h40, 32'h0);
        ignore_frames = 1'b1;
        launch(2, 32'hF000, 200, 0);
        repeat (15) abort_pulse();
        repeat (2) @(negedge clk);
        check(tx_valid == 1'b1, "R9 still retrying after 15 aborts", tx_valid, 1);
        abort_pulse();
        repeat (250) @(negedge clk);
        check(tx_valid == 1'b0, "R9 stopped after limit", tx_valid, 0);
        rd(8'h18, d);
        check(d == 32'h2000 + 200, "R9 give-up status", d, 32'h2000 + 200);
        ignore_frames = 1'b0;
        pos = 0;
        count_valid(5, n);
        check(n == 0, "R9 no resend after give-up", n, 0);
        push(32'h1100, 60);
        launch(3, 32'h1100, 60, 0);
        wait_frames(14);
        rd(8'h1C, d);
        check(d == ok_word(60, 0), "R1 rotation continues after give-up", d, ok_word(60, 0));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_rotation();
        t_order();
        t_zero();
        t_reject();
        t_thresh();
        t_stall();
        t_retry_once();
        t_giveup();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule